// File: doc/BRIEF.md
# eMMC Boot-Read Sequencer

This block runs the host side of an eMMC boot read. When boot is enabled at reset, it pulls the command line low from the first cycle. It can then wait for the device's acknowledge token on DAT0. After that it counts incoming data blocks against a programmed target. When the target is reached it lets the command line go, and boot mode ends. A timeout or a malformed token ends the attempt with an error, and the line is released. Capturing the block contents and checking their CRCs is handled elsewhere. This block only sees a one-cycle strobe per completed block.

The block also tracks the pending-acknowledge condition. It contains the busy detector that follows R1b responses. The pending flag is cleared by any normal data transfer, not only by a token. An attempt that software abandons in mid-wait therefore cannot leave stale state that stops busy detection from working. Busy release is held off only while the sequencer is actually watching DAT0 for a token.

Top module: `emmc_boot_seq`

## Requirements
- R1: If `boot_en` is high when reset ends, `cmd_low` and `boot_active` are high in the first cycle after reset. If `boot_en` is low then, no boot runs, and raising `boot_en` later starts none.
- R2: With `ack_expect` high, the sequencer watches DAT0 at one sample per clock. The token is a 0 start bit, then 0,1,0,1,0, then a 1 stop bit. `ack_seen` rises at the edge that samples the stop bit. Block strobes that arrive before this are not counted.
- R3: With a nonzero `blk_target` N, `boot_done` rises and `cmd_low` falls at the edge that samples the Nth block strobe. With `ack_expect` low, counting starts straight after the first cycle.
- R4: If no complete token arrives within `ack_timeout` cycles of the wait starting (nonzero value), `ack_error` rises and `cmd_low` falls. A value of 0 disables the timeout.
- R5: A token whose six bits after the start bit differ from 0,1,0,1,0,1 raises `ack_error` and releases `cmd_low`.
- R6: With `blk_target` zero, the sequencer keeps counting and keeps `cmd_low` high for any number of strobes, until `abort`.
- R7: `abort` in any active phase releases `cmd_low` at the next edge without raising `boot_done`. It wins over a final block strobe in the same cycle.
- R8: `ack_pending` rises when an acknowledge wait starts. It is cleared by a valid token, by a timeout or bad token, or by a `xfer_activity` pulse. `abort` leaves it set.
- R9: An `r1b_arm` pulse sets `busy`. Outside an acknowledge wait, `busy` clears at the first edge that samples DAT0 high, whatever `ack_pending` holds.
- R10: While an acknowledge wait is in progress, `busy` stays set even when DAT0 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_en | input | 1 | Run a boot read after reset |
| ack_expect | input | 1 | Wait for the acknowledge token before counting |
| blk_target | input | CNT_W | Number of blocks to receive, 0 = until abort |
| ack_timeout | input | TO_W | Token wait limit in cycles, 0 = none |
| blk_strobe | input | 1 | One pulse per completed data block |
| dat0 | input | 1 | Sampled DAT0 line |
| abort | input | 1 | Software abandon of the boot attempt |
| xfer_activity | input | 1 | Pulse on any normal data send or receive |
| r1b_arm | input | 1 | Pulse after an R1b response to start busy tracking |
| cmd_low | output | 1 | Drive the command line low |
| boot_active | output | 1 | Boot read in progress |
| ack_seen | output | 1 | Valid acknowledge token received |
| boot_done | output | 1 | Target block count reached |
| ack_error | output | 1 | Token timed out or was malformed |
| ack_pending | output | 1 | An acknowledge token is still expected |
| busy | output | 1 | Device busy after an R1b response |

## Verification
Two events can collide in one cycle: a software abort and the strobe for the final expected block. The bench programs a two-block target and sends one strobe. It then raises `abort` together with the second strobe. The result is judged correct only if `cmd_low` falls with `boot_done` still low. A second collision is an R1b busy window that overlaps an acknowledge wait. There, DAT0 idles high while `busy` must hold. `busy` must then release on the first high sample after the abort ends the wait, even though `ack_pending` is still set.

// File: rtl/emmc_boot_pkg.sv
package emmc_boot_pkg;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_WAIT_ACK,
        BS_DATA,
        BS_DONE,
        BS_ERROR
    } boot_state_e;

    // six DAT0 samples following the start bit, first sample in the MSB
    localparam int unsigned TOK_BITS = 6;
    localparam logic [TOK_BITS-1:0] TOK_PATTERN = 6'b010101;
    localparam int unsigned TOK_CNT_W = $clog2(TOK_BITS);

endpackage

// File: rtl/boot_ack_rx.sv
module boot_ack_rx
    import emmc_boot_pkg::*;
#(
    parameter int unsigned TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            dat0,
    input  logic [TO_W-1:0] timeout,
    output logic            tok_ok,
    output logic            tok_bad,
    output logic            to_hit
);

    typedef struct packed {
        logic                 rx;
        logic [TOK_CNT_W-1:0] bit_cnt;
        logic [TOK_BITS-2:0]  sh;
        logic [TO_W-1:0]      to_cnt;
    } rx_st_t;

    rx_st_t st_q, st_d;
    logic [TOK_BITS-1:0] full_w;
    logic                last_bit;
    logic [TO_W:0]       to_next;

    assign full_w   = {st_q.sh, dat0};
    assign last_bit = en && st_q.rx && (st_q.bit_cnt == TOK_CNT_W'(TOK_BITS - 1));
    assign to_next  = {1'b0, st_q.to_cnt} + {{TO_W{1'b0}}, 1'b1};

    always_comb begin
        st_d    = st_q;
        tok_ok  = 1'b0;
        tok_bad = 1'b0;
        to_hit  = 1'b0;
        if (!en) begin
            st_d = '0;
        end else begin
            st_d.to_cnt = to_next[TO_W-1:0];
            if (!st_q.rx) begin
                if (!dat0) begin
                    st_d.rx      = 1'b1;
                    st_d.bit_cnt = '0;
                end
            end else if (last_bit) begin
                tok_ok  = (full_w == TOK_PATTERN);
                tok_bad = (full_w != TOK_PATTERN);
                st_d.rx = 1'b0;
            end else begin
                st_d.sh      = {st_q.sh[TOK_BITS-3:0], dat0};
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            end
            to_hit = (timeout != '0) && (to_next == {1'b0, timeout}) && !last_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/boot_blk_cnt.sv
module boot_blk_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             strobe,
    input  logic [CNT_W-1:0] target,
    output logic             last
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_q, st_d;
    logic [CNT_W:0] cnt_next;

    assign cnt_next = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};

    always_comb begin
        st_d = st_q;
        last = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
        end else if (strobe) begin
            st_d.cnt = cnt_next[CNT_W-1:0];
            last     = (target != '0) && (cnt_next == {1'b0, target});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/boot_busy_trk.sv
module boot_busy_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic dat0,
    input  logic hold,
    output logic busy
);

    typedef struct packed {
        logic busy;
    } busy_st_t;

    busy_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (arm)                         st_d.busy = 1'b1;
        else if (st_q.busy && dat0 && !hold) st_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

endmodule

// File: rtl/emmc_boot_seq.sv
module emmc_boot_seq
    import emmc_boot_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_en,
    input  logic             ack_expect,
    input  logic [CNT_W-1:0] blk_target,
    input  logic [TO_W-1:0]  ack_timeout,
    input  logic             blk_strobe,
    input  logic             dat0,
    input  logic             abort,
    input  logic             xfer_activity,
    input  logic             r1b_arm,
    output logic             cmd_low,
    output logic             boot_active,
    output logic             ack_seen,
    output logic             boot_done,
    output logic             ack_error,
    output logic             ack_pending,
    output logic             busy
);

    typedef struct packed {
        boot_state_e state;
        logic        armed;
        logic        seen;
        logic        pend;
    } seq_st_t;

    seq_st_t st_q, st_d;
    logic    tok_ok, tok_bad, to_hit, blk_last;
    logic    in_wait, in_data;

    assign in_wait = (st_q.state == BS_WAIT_ACK);
    assign in_data = (st_q.state == BS_DATA);

    boot_ack_rx #(.TO_W(TO_W)) u_ack_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_wait),
        .dat0    (dat0),
        .timeout (ack_timeout),
        .tok_ok  (tok_ok),
        .tok_bad (tok_bad),
        .to_hit  (to_hit)
    );

    boot_blk_cnt #(.CNT_W(CNT_W)) u_blk_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (in_data),
        .strobe (blk_strobe),
        .target (blk_target),
        .last   (blk_last)
    );

    boot_busy_trk u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (r1b_arm),
        .dat0  (dat0),
        .hold  (in_wait),
        .busy  (busy)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            BS_IDLE: begin
                if (st_q.armed) begin
                    st_d.armed = 1'b0;
                    if (boot_en && !abort) begin
                        if (ack_expect) begin
                            st_d.state = BS_WAIT_ACK;
                            st_d.pend  = 1'b1;
                        end else begin
                            st_d.state = BS_DATA;
                        end
                    end
                end
            end
            BS_WAIT_ACK: begin
                if (abort) begin
                    st_d.state = BS_IDLE;
                end else if (tok_ok) begin
                    st_d.state = BS_DATA;
                    st_d.seen  = 1'b1;
                    st_d.pend  = 1'b0;
                end else if (tok_bad || to_hit) begin
                    st_d.state = BS_ERROR;
                    st_d.pend  = 1'b0;
                end
            end
            BS_DATA: begin
                if (abort)         st_d.state = BS_IDLE;
                else if (blk_last) st_d.state = BS_DONE;
            end
            default: st_d.state = st_q.state;
        endcase
        if (xfer_activity) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= BS_IDLE;
            st_q.armed <= 1'b1;
            st_q.seen  <= 1'b0;
            st_q.pend  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_low     = (st_q.state == BS_IDLE && st_q.armed && boot_en) || in_wait || in_data;
    assign boot_active = cmd_low;
    assign ack_seen    = st_q.seen;
    assign boot_done   = (st_q.state == BS_DONE);
    assign ack_error   = (st_q.state == BS_ERROR);
    assign ack_pending = st_q.pend;

endmodule

// File: rtl/emmc_boot_seq_chk.sv
module emmc_boot_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic abort,
    input logic xfer_activity,
    input logic r1b_arm,
    input logic cmd_low,
    input logic boot_done,
    input logic ack_error,
    input logic ack_pending,
    input logic busy
);

    a_r3_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> !cmd_low);

    a_r4_error_released: assert property (@(posedge clk) disable iff (!rst_n)
        ack_error |-> !cmd_low);

    a_r7_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && cmd_low) |=> (!cmd_low && !boot_done));

    a_r8_xfer_clears: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_activity |=> !ack_pending);

    a_r9_arm_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        r1b_arm |=> busy);

    a_r3_exclusive_end: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({boot_done, ack_error, cmd_low}));

endmodule

bind emmc_boot_seq emmc_boot_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort         (abort),
    .xfer_activity (xfer_activity),
    .r1b_arm       (r1b_arm),
    .cmd_low       (cmd_low),
    .boot_done     (boot_done),
    .ack_error     (ack_error),
    .ack_pending   (ack_pending),
    .busy          (busy)
);

// File: tb/emmc_boot_seq_tb.sv
module emmc_boot_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int TO_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             boot_en = 1'b0, ack_expect = 1'b0;
    logic [CNT_W-1:0] blk_target = '0;
    logic [TO_W-1:0]  ack_timeout = '0;
    logic             blk_strobe = 1'b0, dat0 = 1'b1, abort = 1'b0;
    logic             xfer_activity = 1'b0, r1b_arm = 1'b0;
    logic cmd_low, boot_active, ack_seen, boot_done, ack_error, ack_pending, busy;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    emmc_boot_seq #(.CNT_W(CNT_W), .TO_W(TO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .ack_expect(ack_expect),
        .blk_target(blk_target), .ack_timeout(ack_timeout), .blk_strobe(blk_strobe),
        .dat0(dat0), .abort(abort), .xfer_activity(xfer_activity), .r1b_arm(r1b_arm),
        .cmd_low(cmd_low), .boot_active(boot_active), .ack_seen(ack_seen),
        .boot_done(boot_done), .ack_error(ack_error), .ack_pending(ack_pending), .busy(busy)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic en, input logic ackx, input int tgt, input int to);
        rst_n = 1'b0; boot_en = en; ack_expect = ackx;
        blk_target = CNT_W'(tgt); ack_timeout = TO_W'(to);
        blk_strobe = 0; dat0 = 1; abort = 0; xfer_activity = 0; r1b_arm = 0;
        step(2);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic send_bits(input logic [6:0] bits);
        for (int i = 6; i >= 0; i--) begin
            dat0 = bits[i];
            step(1);
        end
        dat0 = 1'b1;
    endtask

    task automatic pulse_strobe(input int n);
        for (int i = 0; i < n; i++) begin
            blk_strobe = 1'b1; step(1);
        end
        blk_strobe = 1'b0;
    endtask

    task automatic t_reset_states;
        start(1'b0, 1'b0, 2, 0);
        check(cmd_low, 1'b0, "R1 no boot when disabled");
        step(1);
        boot_en = 1'b1; step(3);
        check(cmd_low, 1'b0, "R1 late enable ignored");
        check(boot_active, 1'b0, "R1 late enable no activity");
        start(1'b1, 1'b0, 2, 0);
        check(cmd_low, 1'b1, "R1 cmd low right after reset");
        check(boot_active, 1'b1, "R1 active after reset");
    endtask

    task automatic t_ack_and_count;
        start(1'b1, 1'b1, 3, 0);
        step(1);
        check(ack_pending, 1'b1, "R8 pending on wait start");
        pulse_strobe(2);
        send_bits(7'b0010101);
        check(ack_seen, 1'b1, "R2 token accepted");
        check(ack_pending, 1'b0, "R8 pending cleared by token");
        check(cmd_low, 1'b1, "R2 still driving after token");
        pulse_strobe(2);
        check(boot_done, 1'b0, "R2 early strobes not counted");
        pulse_strobe(1);
        check(boot_done, 1'b1, "R3 done on third block");
        check(cmd_low, 1'b0, "R3 cmd released");
    endtask

    task automatic t_no_ack;
        start(1'b1, 1'b0, 1, 0);
        step(1);
        check(ack_pending, 1'b0, "R3 no wait without ack option");
        pulse_strobe(1);
        check(boot_done, 1'b1, "R3 single block done");
    endtask

    task automatic t_timeout;
        start(1'b1, 1'b1, 2, 20);
        step(20);
        check(ack_error, 1'b0, "R4 no error before limit");
        check(cmd_low, 1'b1, "R4 driving before limit");
        step(1);
        check(ack_error, 1'b1, "R4 timeout error");
        check(cmd_low, 1'b0, "R4 cmd released on timeout");
        check(ack_pending, 1'b0, "R8 pending cleared by timeout");
    endtask

    task automatic t_bad_token;
        start(1'b1, 1'b1, 2, 0);
        step(1);
        send_bits(7'b0011101);
        check(ack_error, 1'b1, "R5 bad token error");
        check(ack_seen, 1'b0, "R5 bad token not seen");
        check(cmd_low, 1'b0, "R5 cmd released");
    endtask

    task automatic t_zero_count;
        start(1'b1, 1'b0, 0, 0);
        step(1);
        pulse_strobe(40);
        check(cmd_low, 1'b1, "R6 still driving with zero target");
        check(boot_done, 1'b0, "R6 never done with zero target");
        abort = 1'b1; step(1); abort = 1'b0;
        check(cmd_low, 1'b0, "R7 abort ends open boot");
        check(boot_done, 1'b0, "R7 abort no done");
    endtask

    task automatic t_abort_vs_last;
        start(1'b1, 1'b0, 2, 0);
        step(1);
        pulse_strobe(1);
        blk_strobe = 1'b1; abort = 1'b1; step(1);
        blk_strobe = 1'b0; abort = 1'b0;
        check(cmd_low, 1'b0, "R7 abort with last block releases");
        check(boot_done, 1'b0, "R7 abort wins over last block");
    endtask

    task automatic t_pending_busy;
        start(1'b1, 1'b1, 2, 0);
        step(1);
        r1b_arm = 1'b1; step(1); r1b_arm = 1'b0;
        step(4);
        check(busy, 1'b1, "R10 busy held during ack wait");
        abort = 1'b1; step(1); abort = 1'b0;
        check(ack_pending, 1'b1, "R8 abort keeps pending");
        check(cmd_low, 1'b0, "R7 abort in ack wait");
        step(1);
        check(busy, 1'b0, "R9 busy released despite pending");
        dat0 = 1'b0; r1b_arm = 1'b1; step(1); r1b_arm = 1'b0;
        step(3);
        check(busy, 1'b1, "R9 busy while dat0 low");
        dat0 = 1'b1; step(1);
        check(busy, 1'b0, "R9 busy clears on dat0 high");
        xfer_activity = 1'b1; step(1); xfer_activity = 1'b0;
        check(ack_pending, 1'b0, "R8 transfer clears pending");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_states();
        t_ack_and_count();
        t_no_ack();
        t_timeout();
        t_bad_token();
        t_zero_count();
        t_abort_vs_last();
        t_pending_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule